// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block takes control of an 8-bit CPU's program counter, flag register and stack for the duration of an interrupt entry or a return-from-interrupt. The CPU core raises `insn_done` when the current instruction retires. The interrupt controller presents a pending request and an 8-bit vector. The block runs a hardware entry sequence of fixed length that saves the machine state on a byte-wide stack and steers execution to page zero. When the CPU decodes a return-from-interrupt, the block runs the mirror sequence, which pops the saved state back into the flag register and the PC.

Entry writes three bytes to the stack and clears the flag register, which blocks further interrupts. It acknowledges the controller in the cycle in which it samples the vector. It loads the PC with the vector in the low byte and zero in the high byte. It then waits out the remaining cycles so that the first fetch always falls in the thirteenth cycle. The stack pointer belongs to this block: a push writes at the pointer and advances it, and a pop first steps it back and then reads. The stack is a single-port memory that returns read data one cycle after the read strobe. Software may set the global enable again inside a handler. Nested entries then stack their frames above the earlier ones.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset, every strobe (`stk_we`, `stk_re`, `irq_ack`, `pc_load`, `flag_load`, `fetch_go`) and `busy` are 0, and `sp` is 0.
- R2: An interrupt is taken only on a clock edge where the block is idle and `insn_done`, `irq_req` and `flag_cur[0]` (the global enable) are all 1. If any of the three is 0, no strobe is issued and `busy` stays 0.
- R3: Counting the cycle after the take edge as entry cycle 1, cycles 1, 2 and 3 each assert `stk_we`. The addresses are sp, sp+1 and sp+2. The data bytes are PC[15:8], PC[7:0] and the flag byte, with values as they were at the take edge. `sp` ends 3 higher.
- R4: Entry cycle 4 asserts `flag_load` with `flag_val` = 0 and asserts `irq_ack`. `irq_ack` is high in no other cycle.
- R5: Entry cycle 5 asserts `pc_load` with `pc_val` = {8'h00, the `irq_vec` value present during cycle 4}.
- R6: `busy` is high in entry cycles 1 to 13. Cycles 6 to 12 carry no strobe, `fetch_go` is high only in cycle 13, and `busy` is 0 in cycle 14.
- R7: A `reti_cmd` sampled while idle starts the exit. Exit cycles 1, 2 and 3 assert `stk_re` at addresses sp-1, sp-2 and sp-3, and `sp` ends 3 lower.
- R8: Exit cycle 3 asserts `flag_load` with the byte read first. Exit cycle 5 asserts `pc_load` with {third byte read, second byte read} and asserts `fetch_go`. `busy` is high in cycles 1 to 5 and low in cycle 6.
- R9: If `reti_cmd` and a valid interrupt take coincide on one idle edge, the exit sequence runs and the interrupt is not taken.
- R10: `reti_cmd`, `insn_done` and `irq_req` are ignored while `busy` is high. The running sequence completes unchanged.
- R11: A second entry taken inside a handler, after software has set the global enable again, pushes its frame at the incremented pointer. Two returns then restore both frames in order and bring `sp` back to its starting value.

Top module port list follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| insn_done | input | 1 | Current instruction has completed this cycle |
| irq_req | input | 1 | Interrupt pending from the controller |
| irq_vec | input | 8 | Vector offset from the controller |
| reti_cmd | input | 1 | Return-from-interrupt decoded |
| pc_cur | input | 16 | CPU program counter |
| flag_cur | input | 8 | CPU flag register, bit 0 is the global enable |
| stk_rdata | input | 8 | Stack read data, valid the cycle after `stk_re` |
| irq_ack | output | 1 | Acknowledge pulse to the controller |
| stk_we | output | 1 | Stack write strobe |
| stk_re | output | 1 | Stack read strobe |
| stk_addr | output | 8 | Stack address |
| stk_wdata | output | 8 | Stack write data |
| sp | output | 8 | Stack pointer |
| pc_load | output | 1 | Load `pc_val` into the PC |
| pc_val | output | 16 | New PC value |
| flag_load | output | 1 | Load `flag_val` into the flag register |
| flag_val | output | 8 | New flag value |
| fetch_go | output | 1 | Restart instruction fetch |
| busy | output | 1 | A sequence is in progress |

## Verification
The hardest state to reach from the ports is a nested interrupt. It needs a frame already on the stack, a handler that has set the global enable again, and a second take while the first frame is still live. The bench models the CPU's PC and flag register, applying `pc_load` and `flag_load` as a core would. It then sets the enable bit between two entries, so that the second frame lands at pointer 3 and the two returns unwind in order. The same CPU model sets up a return and an interrupt that arrive on the same edge, and the bench also drives all inputs while a sequence is under way.

// File: rtl/irs_pkg.sv
package irs_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ENTER = 2'd1,
    ST_LEAVE = 2'd2
  } irs_state_t;

  // Entry step numbers (step k is visible in entry cycle k+1)
  localparam int ENT_PUSH_HI  = 0;
  localparam int ENT_PUSH_LO  = 1;
  localparam int ENT_PUSH_FLG = 2;
  localparam int ENT_CLR      = 3;
  localparam int ENT_VEC      = 4;

  // Exit step numbers
  localparam int LEAVE_LEN    = 5;
  localparam int LV_LAST_POP  = 2;
  localparam int LV_LOAD_FLG  = 2;
  localparam int LV_CAP_LO    = 3;
  localparam int LV_LOAD_PC   = 4;

endpackage

// File: rtl/irs_sp.sv
module irs_sp #(
  parameter int SP_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            inc,
  input  logic            dec,
  output logic [SP_W-1:0] sp_q
);

  always_ff @(posedge clk) begin
    if (rst)      sp_q <= '0;
    else if (inc) sp_q <= sp_q + 1'b1;
    else if (dec) sp_q <= sp_q - 1'b1;
  end

endmodule

// File: rtl/irs_fsm.sv
module irs_fsm
  import irs_pkg::*;
#(
  parameter int ENTRY_LEN = 13,
  parameter int STEP_W    = $clog2(ENTRY_LEN)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  logic              ret,
  output irs_state_t        st_q,
  output irs_state_t        st_d,
  output logic [STEP_W-1:0] step_q,
  output logic [STEP_W-1:0] step_d
);

  localparam logic [STEP_W-1:0] ENT_END = STEP_W'(ENTRY_LEN - 1);
  localparam logic [STEP_W-1:0] LV_END  = STEP_W'(LEAVE_LEN - 1);

  always_comb begin
    st_d   = st_q;
    step_d = step_q;
    unique case (st_q)
      ST_IDLE: begin
        step_d = '0;
        if (ret)       st_d = ST_LEAVE;
        else if (take) st_d = ST_ENTER;
      end
      ST_ENTER: begin
        if (step_q == ENT_END) begin
          st_d   = ST_IDLE;
          step_d = '0;
        end else begin
          step_d = step_q + 1'b1;
        end
      end
      ST_LEAVE: begin
        if (step_q == LV_END) begin
          st_d   = ST_IDLE;
          step_d = '0;
        end else begin
          step_d = step_q + 1'b1;
        end
      end
      default: begin
        st_d   = ST_IDLE;
        step_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      step_q <= '0;
    end else begin
      st_q   <= st_d;
      step_q <= step_d;
    end
  end

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irs_pkg::*;
#(
  parameter int DW        = 8,
  parameter int SP_W      = 8,
  parameter int ENTRY_LEN = 13,
  parameter int GIE_BIT   = 0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            insn_done,
  input  logic            irq_req,
  input  logic [DW-1:0]   irq_vec,
  input  logic            reti_cmd,
  input  logic [2*DW-1:0] pc_cur,
  input  logic [DW-1:0]   flag_cur,
  input  logic [DW-1:0]   stk_rdata,
  output logic            irq_ack,
  output logic            stk_we,
  output logic            stk_re,
  output logic [SP_W-1:0] stk_addr,
  output logic [DW-1:0]   stk_wdata,
  output logic [SP_W-1:0] sp,
  output logic            pc_load,
  output logic [2*DW-1:0] pc_val,
  output logic            flag_load,
  output logic [DW-1:0]   flag_val,
  output logic            fetch_go,
  output logic            busy
);

  localparam int PC_W   = 2 * DW;
  localparam int STEP_W = $clog2(ENTRY_LEN);
  localparam logic [STEP_W-1:0] S_HI    = STEP_W'(ENT_PUSH_HI);
  localparam logic [STEP_W-1:0] S_LO    = STEP_W'(ENT_PUSH_LO);
  localparam logic [STEP_W-1:0] S_FLG   = STEP_W'(ENT_PUSH_FLG);
  localparam logic [STEP_W-1:0] S_CLR   = STEP_W'(ENT_CLR);
  localparam logic [STEP_W-1:0] S_VEC   = STEP_W'(ENT_VEC);
  localparam logic [STEP_W-1:0] S_EEND  = STEP_W'(ENTRY_LEN - 1);
  localparam logic [STEP_W-1:0] L_POP   = STEP_W'(LV_LAST_POP);
  localparam logic [STEP_W-1:0] L_FLG   = STEP_W'(LV_LOAD_FLG);
  localparam logic [STEP_W-1:0] L_LO    = STEP_W'(LV_CAP_LO);
  localparam logic [STEP_W-1:0] L_PC    = STEP_W'(LV_LOAD_PC);
  localparam logic [STEP_W-1:0] L_END   = STEP_W'(LEAVE_LEN - 1);

  irs_state_t        st_q, st_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic              take, ret;
  logic              enter_n, leave_n, push_n, pop_n;
  logic [SP_W-1:0]   sp_q;
  logic [DW-1:0]     lo_q, flg_q, wd_n;

  // Request qualification: only an idle block listens
  assign take = insn_done & irq_req & flag_cur[GIE_BIT];
  assign ret  = reti_cmd;

  irs_fsm #(
    .ENTRY_LEN(ENTRY_LEN),
    .STEP_W   (STEP_W)
  ) u_fsm (
    .clk   (clk),
    .rst   (rst),
    .take  (take),
    .ret   (ret),
    .st_q  (st_q),
    .st_d  (st_d),
    .step_q(step_q),
    .step_d(step_d)
  );

  assign enter_n = (st_d == ST_ENTER);
  assign leave_n = (st_d == ST_LEAVE);
  assign push_n  = enter_n && (step_d <= S_FLG);
  assign pop_n   = leave_n && (step_d <= L_POP);

  irs_sp #(.SP_W(SP_W)) u_sp (
    .clk (clk),
    .rst (rst),
    .inc (push_n),
    .dec (pop_n),
    .sp_q(sp_q)
  );

  assign sp = sp_q;

  always_comb begin
    wd_n = flg_q;
    if (step_d == S_HI)      wd_n = pc_cur[PC_W-1:DW];
    else if (step_d == S_LO) wd_n = lo_q;
  end

  // All outputs are registered from the next-state decode
  always_ff @(posedge clk) begin
    if (rst) begin
      irq_ack   <= 1'b0;
      stk_we    <= 1'b0;
      stk_re    <= 1'b0;
      stk_addr  <= '0;
      stk_wdata <= '0;
      pc_load   <= 1'b0;
      pc_val    <= '0;
      flag_load <= 1'b0;
      flag_val  <= '0;
      fetch_go  <= 1'b0;
      busy      <= 1'b0;
      lo_q      <= '0;
      flg_q     <= '0;
    end else begin
      stk_we    <= push_n;
      stk_re    <= pop_n;
      irq_ack   <= enter_n && (step_d == S_CLR);
      flag_load <= (enter_n && (step_d == S_CLR)) || (leave_n && (step_d == L_FLG));
      pc_load   <= (enter_n && (step_d == S_VEC)) || (leave_n && (step_d == L_PC));
      fetch_go  <= (enter_n && (step_d == S_EEND)) || (leave_n && (step_d == L_END));
      busy      <= (st_d != ST_IDLE);

      if (push_n) begin
        stk_addr  <= sp_q;
        stk_wdata <= wd_n;
      end else if (pop_n) begin
        stk_addr  <= sp_q - 1'b1;
      end

      // Snapshot the low PC byte and flags on the take edge
      if (st_q == ST_IDLE && enter_n) begin
        lo_q  <= pc_cur[DW-1:0];
        flg_q <= flag_cur;
      end

      if (leave_n && (step_d == L_LO)) lo_q <= stk_rdata;

      if (enter_n && (step_d == S_CLR))      flag_val <= '0;
      else if (leave_n && (step_d == L_FLG)) flag_val <= stk_rdata;

      if (enter_n && (step_d == S_VEC))      pc_val <= {{DW{1'b0}}, irq_vec};
      else if (leave_n && (step_d == L_PC))  pc_val <= {stk_rdata, lo_q};
    end
  end

endmodule

// File: rtl/irs_chk.sv
module irs_chk #(
  parameter int DW   = 8,
  parameter int SP_W = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            irq_ack,
  input logic [DW-1:0]   irq_vec,
  input logic            stk_we,
  input logic            stk_re,
  input logic [SP_W-1:0] stk_addr,
  input logic [SP_W-1:0] sp,
  input logic            pc_load,
  input logic [2*DW-1:0] pc_val,
  input logic            flag_load,
  input logic [DW-1:0]   flag_val,
  input logic            fetch_go,
  input logic            busy
);

  p_ack_clears_flags_r4: assert property (@(posedge clk) disable iff (rst)
    irq_ack |-> (flag_load && flag_val == '0));

  p_ack_single_r4: assert property (@(posedge clk) disable iff (rst)
    irq_ack |=> !irq_ack);

  p_vector_page0_r5: assert property (@(posedge clk) disable iff (rst)
    irq_ack |=> (pc_load && pc_val == {{DW{1'b0}}, $past(irq_vec)}));

  p_push_advances_r3: assert property (@(posedge clk) disable iff (rst)
    stk_we |-> (sp == SP_W'(stk_addr + 1'b1)));

  p_pop_predec_r7: assert property (@(posedge clk) disable iff (rst)
    stk_re |-> (sp == stk_addr));

  p_no_rw_overlap_r7: assert property (@(posedge clk) disable iff (rst)
    stk_we |-> !stk_re);

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!stk_we && !stk_re && !pc_load && !flag_load && !irq_ack));

  p_fetch_ends_r6: assert property (@(posedge clk) disable iff (rst)
    fetch_go |=> (!fetch_go && !busy));

endmodule

bind irq_entry_seq irs_chk #(.DW(DW), .SP_W(SP_W)) u_irs_chk (
  .clk      (clk),
  .rst      (rst),
  .irq_ack  (irq_ack),
  .irq_vec  (irq_vec),
  .stk_we   (stk_we),
  .stk_re   (stk_re),
  .stk_addr (stk_addr),
  .sp       (sp),
  .pc_load  (pc_load),
  .pc_val   (pc_val),
  .flag_load(flag_load),
  .flag_val (flag_val),
  .fetch_go (fetch_go),
  .busy     (busy)
);

// File: tb/tb_irq_entry_seq.sv
`timescale 1ns/1ps
module tb_irq_entry_seq;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        insn_done = 1'b0, irq_req = 1'b0, reti_cmd = 1'b0;
  logic [7:0]  irq_vec = 8'h00;
  logic [15:0] cpu_pc;
  logic [7:0]  cpu_fl;
  logic [7:0]  stk_rdata;
  logic        irq_ack, stk_we, stk_re, pc_load, flag_load, fetch_go, busy;
  logic [7:0]  stk_addr, stk_wdata, sp, flag_val;
  logic [15:0] pc_val;
  logic        preset = 1'b0;
  logic [15:0] p_pc = 16'h0;
  logic [7:0]  p_fl = 8'h0;
  logic [7:0]  mem [256];
  int          n_tests = 0, n_fail = 0;

  // pc, flags, vector
  localparam logic [31:0] TBL [4] = '{32'h1234_01_14, 32'hFFFF_FF_00,
                                      32'h00FE_81_FF, 32'h8000_03_28};

  always #2.5 clk = ~clk;

  irq_entry_seq dut (
    .clk(clk), .rst(rst), .insn_done(insn_done), .irq_req(irq_req),
    .irq_vec(irq_vec), .reti_cmd(reti_cmd), .pc_cur(cpu_pc), .flag_cur(cpu_fl),
    .stk_rdata(stk_rdata), .irq_ack(irq_ack), .stk_we(stk_we), .stk_re(stk_re),
    .stk_addr(stk_addr), .stk_wdata(stk_wdata), .sp(sp), .pc_load(pc_load),
    .pc_val(pc_val), .flag_load(flag_load), .flag_val(flag_val),
    .fetch_go(fetch_go), .busy(busy)
  );

  // CPU register model and single-port stack with one-cycle read
  always_ff @(posedge clk) begin
    if (preset) begin
      cpu_pc <= p_pc;
      cpu_fl <= p_fl;
    end else begin
      if (pc_load)   cpu_pc <= pc_val;
      if (flag_load) cpu_fl <= flag_val;
    end
  end

  always @(posedge clk) begin
    if (stk_we) mem[stk_addr] <= stk_wdata;
    if (stk_re) stk_rdata <= mem[stk_addr];
  end

  function automatic logic [63:0] pk(logic we, logic re, logic [7:0] ad, logic [7:0] wd,
                                     logic ack, logic fl, logic [7:0] fv, logic pl,
                                     logic [15:0] pv, logic fg, logic bs);
    return {17'd0, we, re, (we | re) ? ad : 8'h0, we ? wd : 8'h0, ack, fl,
            fl ? fv : 8'h0, pl, pl ? pv : 16'h0, fg, bs};
  endfunction

  function automatic logic [63:0] act_now();
    return pk(stk_we, stk_re, stk_addr, stk_wdata, irq_ack, flag_load, flag_val,
              pc_load, pc_val, fetch_go, busy);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic set_cpu(input logic [15:0] pc, input logic [7:0] fl);
    preset = 1'b1; p_pc = pc; p_fl = fl;
    step();
    preset = 1'b0;
  endtask

  task automatic do_entry(input logic [15:0] pc, input logic [7:0] fl,
                          input logic [7:0] vec, input logic [7:0] sp0, input bit noise);
    logic [63:0] e;
    logic [7:0]  wd;
    string       req;
    set_cpu(pc, fl);
    insn_done = 1'b1; irq_req = 1'b1; irq_vec = vec;
    step();
    insn_done = 1'b0;
    for (int k = 1; k <= 14; k++) begin
      wd  = (k == 1) ? pc[15:8] : (k == 2) ? pc[7:0] : fl;
      e   = pk(k <= 3, 1'b0, 8'(sp0 + k - 1), wd, k == 4, k == 4, 8'h00,
               k == 5, {8'h00, vec}, k == 13, k <= 13);
      req = (noise && k >= 7) ? "R10" : (k <= 3) ? "R3" : (k == 4) ? "R4" :
            (k == 5) ? "R5" : "R6";
      chk(act_now() == e, req, act_now(), e);
      if (k == 4) irq_req = 1'b0;
      if (noise && k >= 6 && k <= 10) begin
        reti_cmd = 1'b1; insn_done = 1'b1; irq_req = 1'b1;
      end else if (noise && k == 11) begin
        reti_cmd = 1'b0; insn_done = 1'b0; irq_req = 1'b0;
      end
      if (k < 14) step();
    end
    chk(cpu_pc == {8'h00, vec} && cpu_fl == 8'h00, "R5", {40'd0, cpu_pc, cpu_fl},
        {40'd0, 8'h00, vec, 8'h00});
    chk(sp == 8'(sp0 + 3), "R3", {56'd0, sp}, {56'd0, 8'(sp0 + 3)});
  endtask

  task automatic do_reti(input logic [7:0] sp0, input logic [15:0] pc,
                         input logic [7:0] fl, input bit also_take);
    logic [63:0] e;
    string       req;
    reti_cmd = 1'b1;
    if (also_take) begin insn_done = 1'b1; irq_req = 1'b1; end
    step();
    reti_cmd = 1'b0; insn_done = 1'b0; irq_req = 1'b0;
    for (int k = 1; k <= 6; k++) begin
      e   = pk(1'b0, k <= 3, 8'(sp0 - k), 8'h00, 1'b0, k == 3, fl,
               k == 5, pc, k == 5, k <= 5);
      req = (also_take && k == 1) ? "R9" : (k <= 2) ? "R7" : "R8";
      chk(act_now() == e, req, act_now(), e);
      if (k < 6) step();
    end
    chk(cpu_pc == pc && cpu_fl == fl, "R8", {40'd0, cpu_pc, cpu_fl}, {40'd0, pc, fl});
    chk(sp == 8'(sp0 - 3), "R7", {56'd0, sp}, {56'd0, 8'(sp0 - 3)});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog all-requirements actual=timeout expected=completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    // R1: reset state
    chk(act_now() == 64'd0 && sp == 8'h00, "R1", act_now() | {48'd0, sp, 8'd0}, 64'd0);

    // R2: enable clear, instruction not done, no request
    set_cpu(16'h0200, 8'h02);
    insn_done = 1'b1; irq_req = 1'b1;
    for (int i = 0; i < 3; i++) begin
      step();
      chk(!busy && !stk_we, "R2", act_now(), 64'd0);
    end
    insn_done = 1'b0;
    set_cpu(16'h0200, 8'h01);
    for (int i = 0; i < 3; i++) begin
      step();
      chk(!busy && !stk_we, "R2", act_now(), 64'd0);
    end
    irq_req = 1'b0; insn_done = 1'b1;
    step();
    step();
    chk(!busy && !stk_we, "R2", act_now(), 64'd0);
    insn_done = 1'b0;

    // Table of entry/exit patterns
    for (int i = 0; i < 4; i++) begin
      do_entry(TBL[i][31:16], TBL[i][15:8], TBL[i][7:0], 8'h00, 1'b0);
      do_reti(8'h03, TBL[i][31:16], TBL[i][15:8], 1'b0);
    end

    // R10: inputs toggled during a running entry
    do_entry(16'h5A5A, 8'h01, 8'h30, 8'h00, 1'b1);
    do_reti(8'h03, 16'h5A5A, 8'h01, 1'b0);

    // R11: nested entry after software re-enables interrupts
    do_entry(16'h4321, 8'h01, 8'h10, 8'h00, 1'b0);
    do_entry(16'h0010, 8'h01, 8'h20, 8'h03, 1'b0);
    do_reti(8'h06, 16'h0010, 8'h01, 1'b0);
    do_reti(8'h03, 16'h4321, 8'h01, 1'b0);
    chk(sp == 8'h00, "R11", {56'd0, sp}, 64'd0);

    // R9: return and take on the same edge
    do_entry(16'h7788, 8'h05, 8'h40, 8'h00, 1'b0);
    set_cpu(16'h0040, 8'h01);
    do_reti(8'h03, 16'h7788, 8'h05, 1'b1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule